// File: doc/BRIEF.md
# Gated Asynchronous Character Transmitter

This block serialises 7-bit characters onto an asynchronous line for a character terminal. A character comes either from the keyboard lines or from an internal data bus and is picked by a source-select input at the moment of a load strobe. The block frames it with a start bit, an even or odd parity bit and one or two stop bits. A rate-select code chooses one of ten standard bit rates between 75 and 19200 baud. A divider on the system clock produces a 16x oversampling tick, and the frame engine counts sixteen of these ticks per bit.

A single holding register lets one character wait while another is on the line. The modem-control side works as follows. A new frame is started only while clear-to-send is high. Request-to-send is raised while anything is pending. Data-terminal-ready follows the terminal's readiness input. A break request forces the line to the spacing level for a fixed time taken from the system clock. A second output carries an identical copy of the serial line so that it can be looped back into a local receiver.

Top module: `serial_tx_gated`

## Requirements
- R1: After reset, `txd` and `txd_loop` are high (marking), and `busy` and `rts` are low.
- R2: A frame is sent least significant bit first, in this order: one low start bit, data bits 0 through 6, one parity bit, then the stop bits (high).
- R3: The parity bit makes the count of ones in data plus parity even when `par_odd` is 0, and odd when `par_odd` is 1.
- R4: With `two_stop` at 0 a frame has one stop bit (10 bit times). With `two_stop` at 1 it has two (11 bit times). Back-to-back frames from the holding register start that many bit times apart, give or take one 16x period.
- R5: Every bit after the start bit lasts exactly 16 x D system clocks, where D = CLK_HZ / (16 x rate). The `rate_sel` codes 0 to 9 select 75, 110, 150, 300, 600, 1200, 2400, 4800, 9600 and 19200 baud, and codes 10 to 15 select 19200. The start bit lasts between 15 x D + 1 and 16 x D clocks.
- R6: The character, parity mode and stop-bit count are sampled on the clock edge where `load` is high. The character is taken from `bus_data` when `use_bus` is 1 and from `kb_data` when it is 0. Later changes to these inputs do not affect that character.
- R7: No frame starts while `cts` is low. A frame already on the line completes normally when `cts` falls. A pending character goes out once `cts` returns high.
- R8: `rts` is high one clock after `busy` goes high and low one clock after it falls. `dtr` equals `term_ready` delayed by one clock.
- R9: A one-clock `brk_req` pulse, while no break is running, holds `txd` low for exactly BREAK_MS milliseconds of system clock (CLK_HZ/1000 x BREAK_MS cycles). After that the line returns high.
- R10: A character loaded during a break is held and goes out after the break ends.
- R11: `busy` is high from the clock after a `load` until the last stop bit of the last pending character ends. One character can wait in the holding register. A `load` that arrives while the holding register is full and cannot be drained that cycle is ignored.
- R12: `txd_loop` always carries the same value as `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| kb_data | input | 7 | Keyboard character lines |
| bus_data | input | 7 | Internal bus character lines |
| use_bus | input | 1 | 1 selects `bus_data`, 0 selects `kb_data` |
| load | input | 1 | Load strobe, one clock per character |
| rate_sel | input | SEL_W (4) | Bit rate code |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| cts | input | 1 | Clear-to-send, high allows a new frame |
| brk_req | input | 1 | Break request pulse |
| term_ready | input | 1 | Terminal readiness |
| txd | output | 1 | Serial line, registered |
| txd_loop | output | 1 | Copy of the serial line for local loopback |
| rts | output | 1 | Request-to-send |
| dtr | output | 1 | Data-terminal-ready |
| busy | output | 1 | A character is held or on the line |

## Verification
Single frames are sent with several characters: alternating bits, all ones, all zeros and mixed values. Each one is paired with a different source, parity mode and stop count, so that a swapped bit order, a wrong parity polarity or a crossed source select each shows up in the decoded data. The edges of a character 0x01 are timed at three rate codes to separate a correct divider and a sixteen-tick bit from an off-by-one count. The stop-bit setting is judged from the spacing between two back-to-back frames. A burst of three loads shows whether the holding register keeps exactly one waiting character and drops the third. The clear-to-send, break and readiness tests show whether gating stops only new frames, and whether a break lasts the exact cycle count and releases a held character.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DATA_W     = 7;
  localparam int OVERSAMPLE = 16;
  localparam int FRAME_MAX  = DATA_W + 4;  // start, data, parity, two stops

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              par_odd;
    logic              two_stop;
  } frame_req_t;

  function automatic int unsigned rate_baud(input int unsigned code);
    case (code)
      0:       return 75;
      1:       return 110;
      2:       return 150;
      3:       return 300;
      4:       return 600;
      5:       return 1200;
      6:       return 2400;
      7:       return 4800;
      8:       return 9600;
      default: return 19200;
    endcase
  endfunction

  function automatic int unsigned rate_div(input int unsigned clk_hz, input int unsigned code);
    int unsigned d;
    d = clk_hz / (OVERSAMPLE * rate_baud(code));
    return (d == 0) ? 1 : d;
  endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud import sertx_pkg::*; #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int          SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             tick16
);

  localparam int unsigned MAX_DIV = rate_div(CLK_HZ, 0);
  localparam int          DIV_W   = $clog2(MAX_DIV + 1);
  localparam int          N_CODES = 1 << SEL_W;

  logic [DIV_W-1:0] div_tab [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_tab
    assign div_tab[g] = DIV_W'(rate_div(CLK_HZ, g));
  end

  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      cnt    <= '0;
      tick16 <= 1'b0;
    end else begin
      sel_q  <= rate_sel;
      tick16 <= 1'b0;
      if (sel_q != rate_sel) begin
        cnt <= '0;
      end else if (cnt == div_tab[sel_q] - 1'b1) begin
        cnt    <= '0;
        tick16 <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sertx_break.sv
module sertx_break #(
  parameter int unsigned CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic active
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      left   <= '0;
    end else if (!active) begin
      if (req) begin
        active <= 1'b1;
        left   <= CW'(CYCLES - 1);
      end
    end else if (left == '0) begin
      active <= 1'b0;
    end else begin
      left <= left - 1'b1;
    end
  end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift import sertx_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       start,
  input  frame_req_t req,
  output logic       active,
  output logic       line
);

  localparam int BW    = $clog2(FRAME_MAX + 1);
  localparam int SUB_W = $clog2(OVERSAMPLE);

  logic [FRAME_MAX-1:0] sr;
  logic [BW-1:0]        bits_left;
  logic [SUB_W-1:0]     sub;
  logic                 par_bit;

  always_comb par_bit = (^req.data) ^ req.par_odd;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      sr        <= '1;
      bits_left <= '0;
      sub       <= '0;
    end else if (start && !active) begin
      active    <= 1'b1;
      sr        <= {2'b11, par_bit, req.data, 1'b0};
      bits_left <= req.two_stop ? BW'(FRAME_MAX) : BW'(FRAME_MAX - 1);
      sub       <= '0;
    end else if (active && tick16) begin
      if (sub == SUB_W'(OVERSAMPLE - 1)) begin
        sub       <= '0;
        sr        <= {1'b1, sr[FRAME_MAX-1:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == BW'(1)) active <= 1'b0;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign line = active ? sr[0] : 1'b1;

endmodule

// File: rtl/serial_tx_gated.sv
module serial_tx_gated import sertx_pkg::*; #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned BREAK_MS = 250,
  parameter int          SEL_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] kb_data,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              use_bus,
  input  logic              load,
  input  logic [SEL_W-1:0]  rate_sel,
  input  logic              two_stop,
  input  logic              par_odd,
  input  logic              cts,
  input  logic              brk_req,
  input  logic              term_ready,
  output logic              txd,
  output logic              txd_loop,
  output logic              rts,
  output logic              dtr,
  output logic              busy
);

  localparam int unsigned BREAK_RAW = (CLK_HZ / 1000) * BREAK_MS;
  localparam int unsigned BREAK_CYC = (BREAK_RAW == 0) ? 1 : BREAK_RAW;

  logic       tick16;
  logic       brk_on;
  logic       sh_active;
  logic       sh_line;
  logic       hold_v;
  frame_req_t hold_req;
  frame_req_t load_req;
  logic       start_go;

  sertx_baud #(.CLK_HZ(CLK_HZ), .SEL_W(SEL_W)) u_baud (
    .clk      (clk),
    .rst      (rst),
    .rate_sel (rate_sel),
    .tick16   (tick16)
  );

  sertx_break #(.CYCLES(BREAK_CYC)) u_brk (
    .clk    (clk),
    .rst    (rst),
    .req    (brk_req),
    .active (brk_on)
  );

  always_comb begin
    load_req.data     = use_bus ? bus_data : kb_data;
    load_req.par_odd  = par_odd;
    load_req.two_stop = two_stop;
  end

  assign start_go = hold_v & ~sh_active & cts & ~brk_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v   <= 1'b0;
      hold_req <= '0;
    end else if (start_go) begin
      hold_v <= load;
      if (load) hold_req <= load_req;
    end else if (load && !hold_v) begin
      hold_v   <= 1'b1;
      hold_req <= load_req;
    end
  end

  sertx_shift u_shift (
    .clk    (clk),
    .rst    (rst),
    .tick16 (tick16),
    .start  (start_go),
    .req    (hold_req),
    .active (sh_active),
    .line   (sh_line)
  );

  assign busy = hold_v | sh_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd      <= 1'b1;
      txd_loop <= 1'b1;
      rts      <= 1'b0;
      dtr      <= 1'b0;
    end else begin
      txd      <= brk_on ? 1'b0 : sh_line;
      txd_loop <= brk_on ? 1'b0 : sh_line;
      rts      <= busy;
      dtr      <= term_ready;
    end
  end

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk import sertx_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              txd,
  input logic              txd_loop,
  input logic              dtr,
  input logic              term_ready,
  input logic              cts,
  input logic              load,
  input logic              busy,
  input logic              sh_active,
  input logic              brk_on,
  input logic              hold_v,
  input logic [DATA_W+1:0] hold_req
);

  AST_LOOP_MATCH: assert property (@(posedge clk) disable iff (rst)
    txd_loop == txd);  // R12

  AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (rst)
    brk_on |=> !txd);  // R9

  AST_CTS_GATE: assert property (@(posedge clk) disable iff (rst)
    (!cts && !sh_active) |=> !sh_active);  // R7

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    (!sh_active && !brk_on) |=> txd);  // R2

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (hold_v && (sh_active || !cts || brk_on)) |=> (hold_v && $stable(hold_req)));  // R11

  AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);  // R11

  AST_DTR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (dtr == $past(term_ready)));  // R8

endmodule

bind serial_tx_gated sertx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .txd        (txd),
  .txd_loop   (txd_loop),
  .dtr        (dtr),
  .term_ready (term_ready),
  .cts        (cts),
  .load       (load),
  .busy       (busy),
  .sh_active  (sh_active),
  .brk_on     (brk_on),
  .hold_v     (hold_v),
  .hold_req   (hold_req)
);

// File: tb/tb_serial_tx_gated.sv
module tb_serial_tx_gated;

  localparam int unsigned CLK_HZ_TB = 1_228_800;
  localparam int unsigned BRK_MS_TB = 1;
  localparam int          BRK_CYC   = (CLK_HZ_TB / 1000) * BRK_MS_TB;
  localparam int          WD_LIMIT  = 150_000;

  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] kb_data, bus_data;
  logic       use_bus, load;
  logic [3:0] rate_sel;
  logic       two_stop, par_odd, cts, brk_req, term_ready;
  logic       txd, txd_loop, rts, dtr, busy;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int cur_div = 4;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_tx_gated #(.CLK_HZ(CLK_HZ_TB), .BREAK_MS(BRK_MS_TB)) dut (
    .clk(clk), .rst(rst), .kb_data(kb_data), .bus_data(bus_data),
    .use_bus(use_bus), .load(load), .rate_sel(rate_sel), .two_stop(two_stop),
    .par_odd(par_odd), .cts(cts), .brk_req(brk_req), .term_ready(term_ready),
    .txd(txd), .txd_loop(txd_loop), .rts(rts), .dtr(dtr), .busy(busy)
  );

  function automatic int tb_div(input int code);
    int r;
    case (code)
      0: r = 75;    1: r = 110;  2: r = 150;  3: r = 300;  4: r = 600;
      5: r = 1200;  6: r = 2400; 7: r = 4800; 8: r = 9600;
      default: r = 19200;
    endcase
    return CLK_HZ_TB / (16 * r);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_rate(input int code);
    rate_sel = 4'(code);
    cur_div  = tb_div(code);
    tick(4);
  endtask

  task automatic pulse_load();
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_txd(input logic lvl, input int limit, output bit seen);
    int w;
    w = 0;
    while (txd !== lvl && w < limit) begin
      @(negedge clk);
      w++;
    end
    seen = (txd === lvl);
  endtask

  task automatic wait_idle();
    int w;
    w = 0;
    while (busy !== 1'b0 && w < 40 * 16 * cur_div) begin
      @(negedge clk);
      w++;
    end
    tick(3);
  endtask

  task automatic rx_frame(input bit two, output logic [6:0] d, output logic p,
                          output logic [1:0] st, output bit got);
    int bc;
    bc = 16 * cur_div;
    d = '0; p = 1'b0; st = 2'b00;
    wait_txd(1'b0, 60 * bc, got);
    if (!got) return;
    tick(8 * cur_div);
    for (int i = 0; i < 7; i++) begin
      tick(bc);
      d[i] = txd;
    end
    tick(bc); p = txd;
    tick(bc); st[0] = txd;
    st[1] = 1'b1;
    if (two) begin
      tick(bc); st[1] = txd;
    end
  endtask

  task automatic test_reset();
    chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(txd_loop === 1'b1, "R1", "txd_loop after reset", int'(txd_loop), 1);
    chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(rts === 1'b0, "R1", "rts after reset", int'(rts), 0);
  endtask

  task automatic send_check(input logic [6:0] kbv, input logic [6:0] busv, input bit ub,
                            input bit podd, input bit two);
    logic [6:0] d, exp;
    logic       p;
    logic [1:0] st;
    bit         got;
    kb_data = kbv; bus_data = busv; use_bus = ub; par_odd = podd; two_stop = two;
    pulse_load();
    kb_data = ~kbv; bus_data = ~busv; use_bus = ~ub; par_odd = ~podd;
    chk(busy === 1'b1, "R11", "busy after load", int'(busy), 1);
    exp = ub ? busv : kbv;
    rx_frame(two, d, p, st, got);
    chk(got, "R2", "frame start seen", int'(got), 1);
    if (ub) chk(d == exp, "R6", "bus character", int'(d), int'(exp));
    else    chk(d == exp, "R2", "keyboard character", int'(d), int'(exp));
    chk(p == ((^exp) ^ podd), "R3", "parity bit", int'(p), int'((^exp) ^ podd));
    chk(st == 2'b11, "R4", "stop bits high", int'(st), 3);
    wait_idle();
    chk(busy === 1'b0, "R11", "busy after frame", int'(busy), 0);
  endtask

  task automatic test_frames();
    set_rate(9);
    send_check(7'h55, 7'h2A, 1'b0, 1'b0, 1'b0);
    send_check(7'h55, 7'h2A, 1'b1, 1'b1, 1'b1);
    send_check(7'h7F, 7'h00, 1'b0, 1'b1, 1'b0);
    send_check(7'h00, 7'h41, 1'b1, 1'b0, 1'b0);
    send_check(7'h4B, 7'h13, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic period_check(input int code);
    int  t0, t1, t2, lo, hi, dv;
    bit  s;
    set_rate(code);
    dv = cur_div;
    kb_data = 7'h01; use_bus = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    pulse_load();
    wait_txd(1'b0, 64 * dv, s); t0 = cyc;
    wait_txd(1'b1, 64 * dv, s); t1 = cyc;
    wait_txd(1'b0, 64 * dv, s); t2 = cyc;
    lo = t1 - t0;
    hi = t2 - t1;
    chk(lo >= 15 * dv + 1 && lo <= 16 * dv, "R5", "start bit length", lo, 16 * dv);
    chk(hi == 16 * dv, "R5", "data bit length", hi, 16 * dv);
    wait_idle();
  endtask

  task automatic test_rates();
    period_check(8);
    period_check(7);
    period_check(9);
  endtask

  task automatic stop_gap(input bit two);
    int t0, t1, dl, ex;
    bit s;
    set_rate(9);
    use_bus = 1'b0; par_odd = 1'b0; two_stop = two;
    kb_data = 7'h7F;
    pulse_load();
    kb_data = 7'h00;
    pulse_load();
    wait_txd(1'b0, 2000, s); t0 = cyc;
    wait_txd(1'b1, 2000, s);
    wait_txd(1'b0, 2000, s); t1 = cyc;
    chk(busy === 1'b1, "R11", "busy between queued frames", int'(busy), 1);
    dl = t1 - t0;
    ex = (two ? 11 : 10) * 16 * cur_div;
    chk(dl >= ex - cur_div && dl <= ex + cur_div, "R4", "start-to-start spacing", dl, ex);
    wait_idle();
  endtask

  task automatic test_hold();
    logic [6:0] d;
    logic       p;
    logic [1:0] st;
    bit         got, s;
    set_rate(9);
    use_bus = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    kb_data = 7'h11; load = 1'b1;
    @(negedge clk); kb_data = 7'h22;
    @(negedge clk); kb_data = 7'h33;
    @(negedge clk); load = 1'b0;
    rx_frame(1'b0, d, p, st, got);
    chk(d == 7'h11, "R11", "first of burst", int'(d), 'h11);
    rx_frame(1'b0, d, p, st, got);
    chk(d == 7'h22, "R11", "held character", int'(d), 'h22);
    wait_idle();
    wait_txd(1'b0, 2 * 10 * 16 * cur_div, s);
    chk(!s, "R11", "third load dropped", int'(s), 0);
    chk(busy === 1'b0, "R11", "idle after burst", int'(busy), 0);
  endtask

  task automatic test_cts();
    logic [6:0] d;
    logic       p;
    logic [1:0] st;
    bit         got, s;
    set_rate(9);
    use_bus = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    cts = 1'b0;
    kb_data = 7'h5A;
    pulse_load();
    tick(1);
    chk(rts === 1'b1, "R8", "rts while pending", int'(rts), 1);
    wait_txd(1'b0, 3 * 10 * 16 * cur_div, s);
    chk(!s, "R7", "no start while cts low", int'(s), 0);
    chk(busy === 1'b1, "R11", "busy while held", int'(busy), 1);
    cts = 1'b1;
    rx_frame(1'b0, d, p, st, got);
    chk(d == 7'h5A, "R7", "released character", int'(d), 'h5A);
    wait_idle();
    chk(rts === 1'b0, "R8", "rts after send", int'(rts), 0);
    kb_data = 7'h33;
    pulse_load();
    tick(2);
    cts = 1'b0;
    rx_frame(1'b0, d, p, st, got);
    chk(d == 7'h33 && st == 2'b11, "R7", "frame completes after cts drop", int'(d), 'h33);
    wait_idle();
    cts = 1'b1;
    tick(2);
  endtask

  task automatic test_dtr();
    term_ready = 1'b0;
    @(negedge clk);
    chk(dtr === 1'b0, "R8", "dtr follows low", int'(dtr), 0);
    term_ready = 1'b1;
    @(negedge clk);
    chk(dtr === 1'b1, "R8", "dtr follows high", int'(dtr), 1);
  endtask

  task automatic test_break();
    logic [6:0] d;
    logic       p;
    logic [1:0] st;
    bit         got, s;
    int         t0, t1;
    set_rate(9);
    use_bus = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    wait_txd(1'b0, 10, s); t0 = cyc;
    chk(s, "R9", "break drives line low", int'(txd), 0);
    kb_data = 7'h4C;
    pulse_load();
    tick(5);
    chk(txd_loop === 1'b0, "R12", "loop copy during break", int'(txd_loop), 0);
    chk(busy === 1'b1, "R10", "character held during break", int'(busy), 1);
    wait_txd(1'b1, 4 * BRK_CYC, s); t1 = cyc;
    chk(t1 - t0 == BRK_CYC, "R9", "break length", t1 - t0, BRK_CYC);
    rx_frame(1'b0, d, p, st, got);
    chk(d == 7'h4C, "R10", "character after break", int'(d), 'h4C);
    wait_idle();
    chk(txd === 1'b1, "R9", "line marking after break", int'(txd), 1);
    chk(txd_loop === txd, "R12", "loop copy equals line", int'(txd_loop), int'(txd));
  endtask

  initial begin
    rst = 1'b1; kb_data = '0; bus_data = '0; use_bus = 1'b0; load = 1'b0;
    rate_sel = 4'd9; two_stop = 1'b0; par_odd = 1'b0; cts = 1'b1;
    brk_req = 1'b0; term_ready = 1'b1;
    tick(5);
    rst = 1'b0;
    tick(1);
    test_reset();
    test_frames();
    test_rates();
    stop_gap(1'b0);
    stop_gap(1'b1);
    test_hold();
    test_cts();
    test_dtr();
    test_break();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", WD_LIMIT, WD_LIMIT);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule